// File: doc/BRIEF.md
# Converter Code-Density Linearity Analyzer

This block measures the step-width error of an 8-bit analog-to-digital converter by the code-density method. While a slow triangle wave sweeps the converter input, every output code arrives on a valid/ready input stream. The block counts how often each code appears. The tallies are not cleared between sweeps, so running the stimulus 100 to 150 times gives finer resolution. For an ideal converter every interior code gets the same tally.

When the host ends the acquisition, the block adds up the tallies of the interior codes 1 to 254 and divides by 254 to get the average. It then works out each code's differential linearity with one shared sequential divider. The value is the tally minus the average, divided by the average, in LSB units. Results leave one code at a time on a valid/ready output stream, as signed fixed-point numbers with 8 fractional bits. The two end codes take in over-range inputs, so they are left out of the average and report zero. Control is three plain signals: `start` clears and opens acquisition, `stop` closes it, and `done`/`err` report completion.

Input back-pressure rules: `in_ready` is high only while acquisition is open. A code counts only in a cycle where `in_valid` and `in_ready` are both high. Output back-pressure rules: once `out_valid` rises it stays high, and `out_code`/`out_dnl` hold their values, until a cycle with `out_ready` high takes the result.

Top module: `adc_dnl_analyzer`

## Requirements
- R1: The block keeps one tally per code (256 bins). Each accepted input handshake adds one to the tally of the presented code.
- R2: `in_ready` is high only between an honoured `start` and the end of the cycle in which `stop` is seen, and it is low in any cycle where `start` is high. A sample presented without a handshake has no effect on any result. A sample accepted in the same cycle as `stop` is counted.
- R3: `start` is honoured only while the block is idle or acquiring. It clears every tally, clears `done` and `err`, and opens acquisition.
- R4: Each tally saturates at 2^CNT_W-1 instead of wrapping.
- R5: The average is floor(sum of the tallies of codes 1..254 / 254).
- R6: For codes 1..254, the result is the difference (tally minus average) times 256, divided by the average and truncated toward zero. It is given as two's complement with 8 fractional bits, and positive values are clamped to 32767.
- R7: Codes 0 and 255 always report 0.
- R8: Results come out in ascending code order 0 to 255, one per output handshake. While `out_ready` is low, `out_valid`, `out_code` and `out_dnl` hold steady.
- R9: If the average is zero, `err` rises, `done` rises and no result is emitted.
- R10: After reset, `done`, `err`, `out_valid` and `in_ready` are low. `done` rises after the result for code 255 is taken and stays high until the next honoured `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clear tallies and open acquisition |
| stop | input | 1 | Close acquisition and begin computing |
| in_valid | input | 1 | Input code valid |
| in_ready | output | 1 | Block accepts a code this cycle |
| in_code | input | 8 | Converter output code |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_code | output | 8 | Code the result belongs to |
| out_dnl | output | 16 | Signed linearity value, 8 fractional bits |
| done | output | 1 | Run finished (level) |
| err | output | 1 | Average tally was zero (level) |

## Verification
Two pairs of events can land in the same cycle. The last sample can arrive together with `stop`, and a sample can arrive together with a restarting `start`. In every run the bench presents its final sample in the same cycle as `stop` and expects it to be counted. It also re-issues `start` during acquisition while `in_valid` carries a stray code, and expects that code to be lost. Both are judged through the emitted results: the bench's own tally model includes the first sample and leaves out the second, then compares all 256 values.

// File: rtl/adc_dnl_pkg.sv
package adc_dnl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_SUM,
    ST_AVG,
    ST_CALC,
    ST_WAIT,
    ST_EMIT
  } an_state_e;
endpackage

// File: rtl/adc_tally_bank.sv
module adc_tally_bank #(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  input  logic [CODE_W-1:0] inc_code,
  input  logic [CODE_W-1:0] rd_idx,
  output logic [CNT_W-1:0]  rd_data
);
  localparam int NCODES = 1 << CODE_W;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] bin_q [NCODES];

  for (genvar g = 0; g < NCODES; g++) begin : g_bin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bin_q[g] <= '0;
      else if (clr) bin_q[g] <= '0;
      else if (inc && inc_code == CODE_W'(g) && bin_q[g] != CMAX)
        bin_q[g] <= bin_q[g] + 1'b1;
    end
  end

  assign rd_data = bin_q[rd_idx];

  AST_TALLY_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && bin_q[inc_code] == CMAX) |=> bin_q[$past(inc_code)] == CMAX); // R4

  AST_TALLY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (bin_q[0] == '0 && bin_q[NCODES-1] == '0)); // R3
endmodule

// File: rtl/adc_seq_divider.sv
module adc_seq_divider #(
  parameter int DW = 32,
  parameter int VW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          done,
  output logic [DW-1:0] quotient
);
  localparam int CNT_W = $clog2(DW + 1);
  localparam int PW    = DW + VW;

  logic [DW-1:0]    dvd_q, orig_q;
  logic [VW-1:0]    dvs_q, rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [VW:0]      rem_n;
  logic             ge;

  assign rem_n = {rem_q, dvd_q[DW-1]};
  assign ge    = rem_n >= {1'b0, dvs_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q <= '0; orig_q <= '0; dvs_q <= '0; rem_q <= '0;
      cnt_q <= '0; busy_q <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        dvd_q  <= dividend;
        orig_q <= dividend;
        dvs_q  <= divisor;
        rem_q  <= '0;
        cnt_q  <= CNT_W'(DW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= ge ? VW'(rem_n - {1'b0, dvs_q}) : rem_n[VW-1:0];
        dvd_q <= {dvd_q[DW-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  assign quotient = dvd_q;

  AST_DIV_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dvs_q != '0) |->
      (PW'(dvd_q) * PW'(dvs_q) <= PW'(orig_q)) &&
      (PW'(orig_q) - PW'(dvd_q) * PW'(dvs_q) < PW'(dvs_q))); // R6
endmodule

// File: rtl/adc_dnl_analyzer.sv
module adc_dnl_analyzer
  import adc_dnl_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 24,
  parameter int FRAC_W = 8,
  parameter int OUT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CODE_W-1:0] out_code,
  output logic [OUT_W-1:0]  out_dnl,
  output logic              done,
  output logic              err
);
  localparam int NCODES   = 1 << CODE_W;
  localparam int SUM_W    = CNT_W + CODE_W;
  localparam int NUM_W    = CNT_W + FRAC_W;
  localparam int DVD_W    = (SUM_W > NUM_W) ? SUM_W : NUM_W;
  localparam int INTERIOR = NCODES - 2;
  localparam logic [CODE_W-1:0] LAST_CODE = '1;
  localparam logic [DVD_W-1:0]  POS_LIM   = DVD_W'((1 << (OUT_W - 1)) - 1);

  an_state_e         state_q;
  logic [CODE_W-1:0] idx_q;
  logic [SUM_W-1:0]  sum_q;
  logic [CNT_W-1:0]  avg_q;
  logic [CNT_W-1:0]  rd_data;
  logic [OUT_W-1:0]  res_q;
  logic              neg_q;
  logic              div_start_q, div_done;
  logic [DVD_W-1:0]  div_dvd_q, div_q;
  logic [CNT_W-1:0]  div_dvs_q;
  logic              start_ok, accept;
  logic [CNT_W-1:0]  abs_diff;
  logic              below;

  assign start_ok  = start && (state_q == ST_IDLE || state_q == ST_ACQ);
  assign in_ready  = (state_q == ST_ACQ) && !start;
  assign accept    = in_valid && in_ready;
  assign out_valid = (state_q == ST_EMIT);
  assign out_code  = idx_q;
  assign out_dnl   = res_q;
  assign below     = rd_data < avg_q;
  assign abs_diff  = below ? (avg_q - rd_data) : (rd_data - avg_q);

  adc_tally_bank #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(start_ok), .inc(accept),
    .inc_code(in_code), .rd_idx(idx_q), .rd_data(rd_data)
  );

  adc_seq_divider #(.DW(DVD_W), .VW(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start_q), .dividend(div_dvd_q),
    .divisor(div_dvs_q), .done(div_done), .quotient(div_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; idx_q <= '0; sum_q <= '0; avg_q <= '0;
      res_q <= '0; neg_q <= 1'b0; done <= 1'b0; err <= 1'b0;
      div_start_q <= 1'b0; div_dvd_q <= '0; div_dvs_q <= '0;
    end else begin
      div_start_q <= 1'b0;
      if (start_ok) begin
        state_q <= ST_ACQ;
        done    <= 1'b0;
        err     <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: ;
          ST_ACQ: if (stop) begin
            state_q <= ST_SUM;
            idx_q   <= CODE_W'(1);
            sum_q   <= '0;
          end
          ST_SUM: begin
            sum_q <= sum_q + SUM_W'(rd_data);
            if (idx_q == CODE_W'(INTERIOR)) begin
              div_start_q <= 1'b1;
              div_dvd_q   <= DVD_W'(sum_q + SUM_W'(rd_data));
              div_dvs_q   <= CNT_W'(INTERIOR);
              state_q     <= ST_AVG;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          ST_AVG: if (div_done) begin
            avg_q <= CNT_W'(div_q);
            idx_q <= '0;
            if (div_q == '0) begin
              err     <= 1'b1;
              done    <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_CALC;
            end
          end
          ST_CALC: begin
            if (idx_q == '0 || idx_q == LAST_CODE) begin
              res_q   <= '0;
              state_q <= ST_EMIT;
            end else begin
              neg_q       <= below;
              div_start_q <= 1'b1;
              div_dvd_q   <= DVD_W'({abs_diff, {FRAC_W{1'b0}}});
              div_dvs_q   <= avg_q;
              state_q     <= ST_WAIT;
            end
          end
          ST_WAIT: if (div_done) begin
            if (neg_q)                 res_q <= OUT_W'(-div_q);
            else if (div_q > POS_LIM)  res_q <= OUT_W'(POS_LIM);
            else                       res_q <= OUT_W'(div_q);
            state_q <= ST_EMIT;
          end
          ST_EMIT: if (out_ready) begin
            if (idx_q == LAST_CODE) begin
              done    <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_CALC;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_dnl))); // R8

  AST_EDGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_code == '0 || out_code == LAST_CODE)) |-> out_dnl == '0); // R7

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !out_valid); // R9

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |-> (!out_valid && !in_ready)); // R10

  AST_START_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !in_ready); // R2
endmodule

// File: tb/adc_dnl_analyzer_tb_top.sv
module adc_dnl_analyzer_tb_top;
  localparam int CW   = 10;
  localparam int TMAX = (1 << CW) - 1;

  typedef struct packed {
    int reps; int skip; int spike_code; int spike_n; int edge_n; int exp_err;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{3, -1,  0,    0,  0, 0},   // flat histogram
    '{4, -1, 10,    4, 20, 0},   // wide code, over-range pile-up
    '{2, 100, 0,    0,  0, 0},   // missing code
    '{0, -1,  0,    0,  5, 1},   // only end codes: zero average
    '{1, -1, 50,  300,  0, 0},   // positive clamp
    '{1, -1,  5, 1030,  0, 0}    // tally saturation
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_code = '0;
  logic in_ready, out_valid, done, err;
  logic [7:0] out_code;
  logic [15:0] out_dnl;

  int nchk = 0, nfail = 0;
  int tally [256];

  always #2 clk = ~clk;

  adc_dnl_analyzer #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .in_valid(in_valid), .in_ready(in_ready), .in_code(in_code),
    .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
    .out_dnl(out_dnl), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int c, input bit with_stop);
    @(negedge clk);
    in_valid = 1'b1; in_code = 8'(c); stop = with_stop;
    if (tally[c] < TMAX) tally[c]++;
  endtask

  function automatic int model_avg();
    int s = 0;
    for (int c = 1; c < 255; c++) s += tally[c];
    return s / 254;
  endfunction

  function automatic int model_dnl(input int c, input int a);
    int d, m;
    if (c == 0 || c == 255) return 0;
    d = tally[c] - a;
    m = ((d < 0) ? -d : d) * 256 / a;
    if (d < 0) return -m;
    return (m > 32767) ? 32767 : m;
  endfunction

  task automatic run_vec(input vec_t v);
    int a, got, cyc;
    logic [7:0] held_code;
    logic [15:0] held_dnl;
    bit holding;
    // stray samples while idle (R2)
    @(negedge clk); in_valid = 1'b1; in_code = 8'd7;
    #1 chk(in_ready == 1'b0, "R2 idle in_ready", int'(in_ready), 0);
    @(negedge clk); in_valid = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0; in_valid = 1'b1; in_code = 8'd9;   // counted, then cleared
    @(negedge clk); start = 1'b1;                                     // restart with sample: dropped
    #1 chk(in_ready == 1'b0, "R3 in_ready during start", int'(in_ready), 0);
    @(negedge clk); start = 1'b0; in_valid = 1'b0;
    #1 chk(done == 1'b0 && err == 1'b0, "R3 flags cleared", int'({done, err}), 0);
    for (int c = 0; c < 256; c++) tally[c] = 0;
    for (int r = 0; r < v.reps; r++)
      for (int c = 0; c < 256; c++) if (c != v.skip) send(c, 1'b0);
    for (int k = 0; k < v.spike_n; k++) send(v.spike_code, 1'b0);
    for (int k = 0; k < v.edge_n; k++) begin send(0, 1'b0); send(255, 1'b0); end
    send(128, 1'b1);                                                  // last sample with stop (R2)
    @(negedge clk); stop = 1'b0; in_code = 8'd7;                      // junk held during compute
    #1 chk(in_ready == 1'b0, "R2 closed after stop", int'(in_ready), 0);
    a = model_avg();
    got = 0; cyc = 0; holding = 0;
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (holding) begin
        chk(out_valid && out_code == held_code && out_dnl == held_dnl,
            "R8 hold under back-pressure", int'(out_dnl), int'(held_dnl));
        holding = 0;
      end
      out_ready = (cyc % 3) != 0;
      #1;
      if (out_valid && out_ready) begin
        chk(int'(out_code) == got, "R8 code order", int'(out_code), got);
        if (out_code == 0 || out_code == 255)
          chk($signed(out_dnl) == 0, "R7 end code zero", int'($signed(out_dnl)), 0);
        else
          chk(int'($signed(out_dnl)) == model_dnl(int'(out_code), a),
              "R6 linearity value", int'($signed(out_dnl)), model_dnl(int'(out_code), a));
        got++;
      end else if (out_valid) begin
        held_code = out_code; held_dnl = out_dnl; holding = 1;
      end
    end
    out_ready = 1'b0; in_valid = 1'b0;
    chk(int'(err) == v.exp_err, "R9 error flag", int'(err), v.exp_err);
    chk(got == (v.exp_err ? 0 : 256), "R10 result count", got, v.exp_err ? 0 : 256);
    @(negedge clk);
    chk(done == 1'b1, "R10 done held", int'(done), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk({done, err, out_valid, in_ready} == 4'b0, "R10 reset state",
           int'({done, err, out_valid, in_ready}), 0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);   // R1 R4 R5 exercised through results
    // stop while idle must not start a run
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    #1 chk(out_valid == 1'b0 && done == 1'b1, "R3 stop ignored when idle",
           int'(out_valid), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule